// File: doc/BRIEF.md
# Single-Precision Floating-Point Three-Way Comparator

This block orders two IEEE-754 binary32 operands, given as raw 32-bit words, and reports the result in three forms at once. It classifies each operand from its bit pattern alone. Two three-way results are produced, and they differ only in how an unordered pair is reported. The "le-policy" result reports an unordered pair as greater. The "ge-policy" result reports it as less. A one-bit flag also marks the unordered case.

The comparison treats the two words as signed 32-bit integers. The integer sense is correct when at least one operand is non-negative. When both operands are negative, the sense is reversed. Two zeros always compare equal, whatever their signs.

A parameter selects the timing. In the default registered form, the results appear one clock after a valid input. They hold while no valid input arrives. Setting `REGISTERED` to 0 makes the path combinational.

Top module: `fp32_order_unit`

## Requirements
- R1: `unord` is 1 exactly when at least one operand has its low 31 bits strictly above 0x7F800000 (a NaN). The patterns 0x7F800000 and 0xFF800000 (infinities) are not NaN.
- R2: When the pair is unordered, `le_res` is greater (2'b01).
- R3: When the pair is unordered, `ge_res` is less (2'b11).
- R4: Both results use the codes 2'b11 for less, 2'b00 for equal and 2'b01 for greater. The code 2'b10 never appears after reset.
- R5: Two operands whose low 31 bits are all zero compare equal for every combination of sign bits.
- R6: For ordered, non-zero pairs in which at least one word has bit 31 clear, the result matches a signed 32-bit integer comparison of the two words.
- R7: For ordered pairs in which both words have bit 31 set, the result is the reverse of the signed integer comparison. Identical words compare equal.
- R8: Two infinities of the same sign compare equal. +Inf (0x7F800000) is greater than every finite value, and -Inf (0xFF800000) is less than every finite value.
- R9: For an ordered pair, `le_res` and `ge_res` carry the same code.
- R10: In the registered form, a result sampled with `in_valid` high appears on the outputs one clock later, with `out_valid` high. `out_valid` is low in the cycle after `in_valid` is low.
- R11: While `in_valid` is low, operand changes have no effect on `le_res`, `ge_res` or `unord`.
- R12: A synchronous active-low reset sets `out_valid` to 0, both results to 2'b00 and `unord` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands are valid this cycle |
| op_a | input | 32 | First operand, raw binary32 word |
| op_b | input | 32 | Second operand, raw binary32 word |
| out_valid | output | 1 | Results are valid |
| le_res | output | 2 | Three-way result, unordered reported as greater |
| ge_res | output | 2 | Three-way result, unordered reported as less |
| unord | output | 1 | At least one operand is NaN |

## Verification
The only internal state is the output register, so most faults show up as a wrong result code in the cycle right after the operands are accepted. A misplaced sign flip inverts the order only for pairs in which both operands are negative. For that reason, random stimulus is weighted toward negative pairs, signed zeros, infinities and NaN boundaries near 0x7F800000.

A register that updates when it should not would show on the outputs one cycle after an idle cycle that carries changed operands. The bench therefore changes the operands during idle cycles and checks that the outputs stay the same.

// File: rtl/fpcmp_pkg.sv
// Shared types for the binary32 comparator.
// Assumes: result codes are two-bit signed values.
package fpcmp_pkg;
    typedef enum logic [1:0] {
        ORD_LT = 2'b11,
        ORD_EQ = 2'b00,
        ORD_GT = 2'b01
    } ord_t;
endpackage

// File: rtl/fpcmp_classify.sv
// Classifies one raw floating-point word as NaN and/or zero magnitude.
// Assumes: IEEE-754 interchange layout {sign, exponent, mantissa}.
module fpcmp_classify #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] word,
    output logic                 is_nan,
    output logic                 is_zero
);
    localparam int MAG_W = EXP_W + MAN_W;
    localparam logic [MAG_W-1:0] INF_MAG = {{EXP_W{1'b1}}, {MAN_W{1'b0}}};

    logic [MAG_W-1:0] mag;

    // Strip the sign and test the magnitude against the infinity pattern.
    always_comb begin
        mag     = word[MAG_W-1:0];
        is_nan  = (mag > INF_MAG);
        is_zero = (mag == '0);
    end
endmodule

// File: rtl/fpcmp_core.sv
// Combinational ordering of two words using a signed-integer compare,
// reversed when both operands are negative; applies both NaN policies.
// Assumes: classification inputs come from fpcmp_classify on the same words.
module fpcmp_core
    import fpcmp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         a_nan,
    input  logic         b_nan,
    input  logic         a_zero,
    input  logic         b_zero,
    output ord_t         le_code,
    output ord_t         ge_code,
    output logic         unordered
);
    logic  int_lt;
    logic  int_eq;
    logic  both_neg;
    ord_t  ordered;

    // Integer relation of the raw words and the sign-flip condition.
    always_comb begin
        int_lt   = ($signed(a) < $signed(b));
        int_eq   = (a == b);
        both_neg = a[W-1] & b[W-1];
    end

    // Ordered result: zeros equal, else integer order with sign-dependent flip.
    always_comb begin
        if (a_zero && b_zero)
            ordered = ORD_EQ;
        else if (int_eq)
            ordered = ORD_EQ;
        else if (int_lt ^ both_neg)
            ordered = ORD_LT;
        else
            ordered = ORD_GT;
    end

    // NaN policies: le-style reports greater, ge-style reports less.
    always_comb begin
        unordered = a_nan | b_nan;
        le_code   = unordered ? ORD_GT : ordered;
        ge_code   = unordered ? ORD_LT : ordered;
    end
endmodule

// File: rtl/fpcmp_stage.sv
// Output stage: a one-clock register with valid tracking and hold,
// or a straight pass-through when REGISTERED is 0.
// Assumes: synchronous active-low reset.
module fpcmp_stage
    import fpcmp_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  ord_t       le_in,
    input  ord_t       ge_in,
    input  logic       un_in,
    output logic       out_valid,
    output logic [1:0] le_out,
    output logic [1:0] ge_out,
    output logic       un_out
);
    generate
        if (REGISTERED) begin : g_reg
            ord_t le_q;
            ord_t ge_q;
            logic un_q;
            logic vld_q;

            // Capture results on valid input, hold otherwise.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    le_q  <= ORD_EQ;
                    ge_q  <= ORD_EQ;
                    un_q  <= 1'b0;
                    vld_q <= 1'b0;
                end else begin
                    vld_q <= in_valid;
                    if (in_valid) begin
                        le_q <= le_in;
                        ge_q <= ge_in;
                        un_q <= un_in;
                    end
                end
            end

            // Drive the ports from the register.
            always_comb begin
                out_valid = vld_q;
                le_out    = le_q;
                ge_out    = ge_q;
                un_out    = un_q;
            end

            assert_nan_policy_R2: assert property (@(posedge clk) disable iff (!rst_n)
                un_out |-> (le_out == 2'b01));
            assert_nan_policy_R3: assert property (@(posedge clk) disable iff (!rst_n)
                un_out |-> (ge_out == 2'b11));
            assert_code_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (le_out != 2'b10) && (ge_out != 2'b10));
            assert_policies_agree_R9: assert property (@(posedge clk) disable iff (!rst_n)
                !un_out |-> (le_out == ge_out));
            assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            assert_idle_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
            assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> ($stable(le_out) && $stable(ge_out) && $stable(un_out)));
        end else begin : g_comb
            // Pass results straight through.
            always_comb begin
                out_valid = in_valid;
                le_out    = le_in;
                ge_out    = ge_in;
                un_out    = un_in;
            end
        end
    endgenerate
endmodule

// File: rtl/fp32_order_unit.sv
// Top: binary32 three-way comparator with le-style and ge-style NaN
// policies plus an unordered flag. Classification works on bit patterns only.
// Assumes: no exception flags, no quiet/signalling NaN distinction.
module fp32_order_unit
    import fpcmp_pkg::*;
#(
    parameter int EXP_W      = 8,
    parameter int MAN_W      = 23,
    parameter bit REGISTERED = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [EXP_W+MAN_W:0] op_a,
    input  logic [EXP_W+MAN_W:0] op_b,
    output logic                 out_valid,
    output logic [1:0]           le_res,
    output logic [1:0]           ge_res,
    output logic                 unord
);
    localparam int W = EXP_W + MAN_W + 1;

    logic [W-1:0] ops  [2];
    logic         nan  [2];
    logic         zero [2];
    ord_t         le_c;
    ord_t         ge_c;
    logic         un_c;

    // Gather operands for the per-operand classifiers.
    always_comb begin
        ops[0] = op_a;
        ops[1] = op_b;
    end

    generate
        for (genvar i = 0; i < 2; i++) begin : g_cls
            fpcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) cls_i (
                .word    (ops[i]),
                .is_nan  (nan[i]),
                .is_zero (zero[i])
            );
        end
    endgenerate

    fpcmp_core #(.W(W)) core_i (
        .a         (op_a),
        .b         (op_b),
        .a_nan     (nan[0]),
        .b_nan     (nan[1]),
        .a_zero    (zero[0]),
        .b_zero    (zero[1]),
        .le_code   (le_c),
        .ge_code   (ge_c),
        .unordered (un_c)
    );

    fpcmp_stage #(.REGISTERED(REGISTERED)) stage_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .le_in     (le_c),
        .ge_in     (ge_c),
        .un_in     (un_c),
        .out_valid (out_valid),
        .le_out    (le_res),
        .ge_out    (ge_res),
        .un_out    (unord)
    );
endmodule

// File: tb/fp32_order_unit_tb.sv
module fp32_order_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        out_valid;
    logic [1:0]  le_res;
    logic [1:0]  ge_res;
    logic        unord;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    fp32_order_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .out_valid(out_valid),
        .le_res(le_res), .ge_res(ge_res), .unord(unord)
    );

    function automatic bit is_nan_w(input logic [31:0] w);
        return w[30:0] > 31'h7F800000;
    endfunction

    // Ordered expectation from integer comparisons (R5, R6, R7).
    function automatic logic [1:0] ordered_ref(input logic [31:0] a, input logic [31:0] b);
        if (a[30:0] == 0 && b[30:0] == 0) return 2'b00;
        if (a == b) return 2'b00;
        if (a[31] && b[31]) return (a > b) ? 2'b11 : 2'b01;
        return ($signed(a) < $signed(b)) ? 2'b11 : 2'b01;
    endfunction

    function automatic logic [1:0] le_ref(input logic [31:0] a, input logic [31:0] b);
        if (is_nan_w(a) || is_nan_w(b)) return 2'b01;
        return ordered_ref(a, b);
    endfunction

    function automatic logic [1:0] ge_ref(input logic [31:0] a, input logic [31:0] b);
        if (is_nan_w(a) || is_nan_w(b)) return 2'b11;
        return ordered_ref(a, b);
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h (a=%h b=%h)", req, got, exp, op_a, op_b);
        end
    endtask

    logic [1:0] last_le, last_ge;
    logic       last_un;

    // Present one pair, check one clock later against the reference.
    task automatic apply(input logic [31:0] a, input logic [31:0] b, input string req);
        @(negedge clk);
        in_valid = 1'b1; op_a = a; op_b = b;
        @(negedge clk);
        last_le = le_ref(a, b);
        last_ge = ge_ref(a, b);
        last_un = is_nan_w(a) || is_nan_w(b);
        chk({req, " R10 valid"}, {31'b0, out_valid}, 32'd1);
        chk({req, " R2/R9 le"}, {30'b0, le_res}, {30'b0, last_le});
        chk({req, " R3/R9 ge"}, {30'b0, ge_res}, {30'b0, last_ge});
        chk({req, " R1 unord"}, {31'b0, unord}, {31'b0, last_un});
    endtask

    // Idle cycle with changed operands: outputs must hold (R11).
    task automatic idle_hold(input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        in_valid = 1'b0; op_a = a; op_b = b;
        @(negedge clk);
        chk("R10 idle valid", {31'b0, out_valid}, 32'd0);
        chk("R11 hold le", {30'b0, le_res}, {30'b0, last_le});
        chk("R11 hold ge", {30'b0, ge_res}, {30'b0, last_ge});
        chk("R11 hold unord", {31'b0, unord}, {31'b0, last_un});
    endtask

    function automatic logic [31:0] gen_op();
        logic [31:0] r = $urandom;
        case ($urandom % 7)
            0: return {r[31], 31'h0};
            1: return {r[31], 31'h7F800000};
            2: return {r[31], 8'hFF, r[22:0] | 23'h1};
            3: return {r[31], 8'h00, r[22:0]};
            4: return {1'b1, r[30:0]};
            5: return {r[31], 8'hFF, 23'h1};
            default: return r;
        endcase
    endfunction

    initial begin
        repeat (1000000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 reset valid", {31'b0, out_valid}, 32'd0);
        chk("R12 reset le", {30'b0, le_res}, 32'd0);
        chk("R12 reset ge", {30'b0, ge_res}, 32'd0);
        chk("R12 reset unord", {31'b0, unord}, 32'd0);
        rst_n = 1'b1;

        // R5 signed zeros
        apply(32'h00000000, 32'h80000000, "R5 +0/-0");
        chk("R5 equal", {30'b0, le_res}, 32'd0);
        apply(32'h80000000, 32'h80000000, "R5 -0/-0");
        // R6 mixed signs and positives
        apply(32'h3F800000, 32'h40000000, "R6 1<2");
        chk("R6 less code", {30'b0, le_res}, 32'd3);
        apply(32'hBF800000, 32'h3F800000, "R6 -1<1");
        chk("R6 neg<pos", {30'b0, ge_res}, 32'd3);
        // R7 both negative
        apply(32'hC0000000, 32'hBF800000, "R7 -2<-1");
        chk("R7 reversed", {30'b0, le_res}, 32'd3);
        apply(32'hBF800000, 32'hBF800000, "R7 equal words");
        chk("R7 equal", {30'b0, le_res}, 32'd0);
        // R8 infinities
        apply(32'h7F800000, 32'h7F800000, "R8 +inf=+inf");
        chk("R8 inf eq", {30'b0, le_res}, 32'd0);
        apply(32'h7F800000, 32'h7F7FFFFF, "R8 +inf>max");
        chk("R8 inf gt", {30'b0, le_res}, 32'd1);
        apply(32'hFF800000, 32'hFF7FFFFF, "R8 -inf<-max");
        chk("R8 -inf lt", {30'b0, le_res}, 32'd3);
        // R1 NaN boundary, R2/R3 policies
        apply(32'h7F800001, 32'h3F800000, "R1 min NaN");
        chk("R1 nan flag", {31'b0, unord}, 32'd1);
        chk("R2 le gt", {30'b0, le_res}, 32'd1);
        chk("R3 ge lt", {30'b0, ge_res}, 32'd3);
        apply(32'h00000000, 32'hFFC00000, "R1 neg NaN");
        apply(32'hFF800000, 32'h7F800000, "R1 inf not NaN");
        chk("R1 inf flag", {31'b0, unord}, 32'd0);
        idle_hold(32'h7FC00000, 32'h00000000);

        // Random mix, R4 legality checked on every result
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a = gen_op();
            logic [31:0] b;
            case ($urandom % 4)
                0: b = a;
                1: b = a ^ 32'h80000000;
                2: b = a + 32'd1;
                default: b = gen_op();
            endcase
            apply(a, b, "R6/R7 random");
            chk("R4 code le", {31'b0, le_res == 2'b10}, 32'd0);
            if (i % 16 == 0) idle_hold(gen_op(), gen_op());
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule